// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block resolves read-after-write hazards for the two ALU operands of a five-stage in-order integer pipeline. For each operand it compares the source register number of the instruction in the execute stage with the destination register of the two older instructions still in flight. One of those instructions has just left execute, and the other is about to write back. If an older instruction will write the register being read, its result replaces the stale value that was read from the register file at decode.

A selection code is produced for each operand and drives a three-way operand multiplexer. The inputs to that multiplexer are the decoded register value, the ALU result one stage ahead, and the write-back value two stages ahead. The younger of the two in-flight results takes priority. Register zero is never forwarded, and neither is the destination field of an instruction that does not write the register file. A value written back in the same cycle as it is read needs no path here, because the register file writes in the first half of the cycle and reads in the second half.

The selects and operands are captured in output registers. A bench can therefore apply one pipeline snapshot per clock and read the decision one clock later.

Top module: `fwd_unit_top`

## Requirements
- R1: While reset is asserted, and at once when it is asserted, both selects read 2'b00 and both operand outputs read zero.
- R2: Select encoding: 2'b00 picks the decoded operand value, 2'b10 picks the ALU result one stage ahead, 2'b01 picks the write-back value. The code 2'b11 is never produced. The operand output equals the source that the select names.
- R3: An operand takes the ALU result one stage ahead when that stage writes a register, its destination is nonzero, and its destination equals the operand's source register number.
- R4: An operand takes the write-back value when the write-back stage writes a register, its destination is nonzero and equals the source number, and the R3 condition for that operand is false.
- R5: When both stages match the same source register, the ALU result one stage ahead wins, so chained writes deliver the most recent value.
- R6: A destination of register zero never causes forwarding, even when the source is also register zero.
- R7: A matching destination on a stage whose write flag is low causes no forwarding.
- R8: The two operands are decided independently. In one cycle each may forward from a different stage, or both from the same stage.
- R9: The selects and operands are registered. A change at the inputs appears at the outputs after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_rs | input | 5 | First source register number of the execute-stage instruction |
| ex_rt | input | 5 | Second source register number of the execute-stage instruction |
| ex_a_val | input | 32 | First operand value read at decode |
| ex_b_val | input | 32 | Second operand value read at decode |
| mem_rd | input | 5 | Destination register of the stage one ahead |
| mem_wr | input | 1 | Register-write flag of the stage one ahead |
| mem_alu | input | 32 | ALU result held one stage ahead |
| wb_rd | input | 5 | Destination register of the write-back stage |
| wb_wr | input | 1 | Register-write flag of the write-back stage |
| wb_val | input | 32 | Value being written back |
| sel_a | output | 2 | Registered select for the first operand |
| sel_b | output | 2 | Registered select for the second operand |
| op_a | output | 32 | Registered forwarded first operand |
| op_b | output | 32 | Registered forwarded second operand |

## Verification
The properties assume that every input is a known value that is stable at each rising edge, and that the pipeline inputs for the clock just before a check were sampled while reset was inactive. The properties qualify each check on the previous reset level to cover the second point. The bench changes inputs only on falling edges and holds all inputs at zero during reset. Its snapshots are real instruction sequences: a subtract followed by four dependent readers, a chain of three adds on one register, and contrived cases for register zero, write flags low, and dual or split matches.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;
  localparam int N_OPND = 2;

  typedef enum logic [1:0] {
    SEL_IDEX = 2'b00,
    SEL_WB   = 2'b01,
    SEL_EX   = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wr,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_wr,
  output fwd_sel_e      sel
);
  logic ex_hit;
  logic wb_hit;

  // Younger producer checked first; register zero is never a producer.
  always_comb begin
    ex_hit = ex_wr && (ex_rd != '0) && (ex_rd == src);
    wb_hit = wb_wr && (wb_rd != '0) && (wb_rd == src);
    if (ex_hit)      sel = SEL_EX;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_IDEX;
  end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  fwd_sel_e      sel,
  input  logic [DW-1:0] id_val,
  input  logic [DW-1:0] ex_val,
  input  logic [DW-1:0] wb_val,
  output logic [DW-1:0] y
);
  always_comb begin
    case (sel)
      SEL_EX:  y = ex_val;
      SEL_WB:  y = wb_val;
      default: y = id_val;
    endcase
  end
endmodule

// File: rtl/fwd_unit_top.sv
module fwd_unit_top
  import fwd_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ex_rs,
  input  logic [RW-1:0] ex_rt,
  input  logic [DW-1:0] ex_a_val,
  input  logic [DW-1:0] ex_b_val,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic [DW-1:0] mem_alu,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_wr,
  input  logic [DW-1:0] wb_val,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b
);
  localparam int NO = N_OPND;

  logic [RW-1:0] src_num [NO];
  logic [DW-1:0] src_val [NO];
  fwd_sel_e      sel_d   [NO];
  logic [DW-1:0] op_d    [NO];
  fwd_sel_e      sel_q   [NO];
  logic [DW-1:0] op_q    [NO];

  always_comb begin
    src_num[0] = ex_rs;
    src_num[1] = ex_rt;
    src_val[0] = ex_a_val;
    src_val[1] = ex_b_val;
  end

  for (genvar g = 0; g < NO; g++) begin : g_opnd
    fwd_select #(.RW(RW)) u_sel (
      .src   (src_num[g]),
      .ex_rd (mem_rd),
      .ex_wr (mem_wr),
      .wb_rd (wb_rd),
      .wb_wr (wb_wr),
      .sel   (sel_d[g])
    );

    fwd_mux #(.DW(DW)) u_mux (
      .sel    (sel_d[g]),
      .id_val (src_val[g]),
      .ex_val (mem_alu),
      .wb_val (wb_val),
      .y      (op_d[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[g] <= SEL_IDEX;
        op_q[g]  <= '0;
      end else begin
        sel_q[g] <= sel_d[g];
        op_q[g]  <= op_d[g];
      end
    end
  end

  always_comb begin
    sel_a = sel_q[0];
    sel_b = sel_q[1];
    op_a  = op_q[0];
    op_b  = op_q[1];
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_a) && $onehot0(sel_b)); // R2

  AST_EX_VALUE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'b10) |-> (op_a == $past(mem_alu))); // R2

  AST_WB_VALUE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b == 2'b01) |-> (op_b == $past(wb_val))); // R2

  AST_EX_WINS_A: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mem_wr) && $past(mem_rd) != '0 && $past(mem_rd) == $past(ex_rs))
      |-> (sel_a == 2'b10)); // R5

  AST_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_rd) == '0 && $past(wb_rd) == '0) |-> (sel_a == 2'b00 && sel_b == 2'b00)); // R6

  AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mem_wr) && !$past(wb_wr)) |-> (sel_a == 2'b00 && sel_b == 2'b00)); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_b == 2'b00 && $past(rst_n)) |-> (op_b == $past(ex_b_val))); // R9
endmodule

// File: tb/fwd_unit_top_tb.sv
`timescale 1ns/1ps
module fwd_unit_top_tb_top;
  localparam int RW = 5;
  localparam int DW = 32;
  localparam int NV = 14;

  typedef struct packed {
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] mrd;
    logic       mwr;
    logic [4:0] wrd;
    logic       wwr;
    logic [1:0] ea;
    logic [1:0] eb;
    logic [3:0] req;
  } vec_t;

  // rs, rt, mem_rd, mem_wr, wb_rd, wb_wr, exp sel_a, exp sel_b, requirement
  localparam vec_t VECS [NV] = '{
    '{5'd1,  5'd3,  5'd0,  1'b0, 5'd0,  1'b0, 2'b00, 2'b00, 4'd2}, // R2 sub alone
    '{5'd2,  5'd5,  5'd2,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00, 4'd3}, // R3 and after sub
    '{5'd6,  5'd2,  5'd12, 1'b1, 5'd2,  1'b1, 2'b00, 2'b01, 4'd4}, // R4 or
    '{5'd2,  5'd2,  5'd13, 1'b1, 5'd12, 1'b1, 2'b00, 2'b00, 4'd4}, // R4 add, no match
    '{5'd2,  5'd15, 5'd14, 1'b1, 5'd13, 1'b1, 2'b00, 2'b00, 4'd4}, // R4 sw
    '{5'd1,  5'd3,  5'd1,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00, 4'd3}, // R3 chain second add
    '{5'd1,  5'd4,  5'd1,  1'b1, 5'd1,  1'b1, 2'b10, 2'b00, 4'd5}, // R5 chain third add
    '{5'd5,  5'd7,  5'd5,  1'b1, 5'd7,  1'b1, 2'b10, 2'b01, 4'd8}, // R8 split stages
    '{5'd9,  5'd9,  5'd9,  1'b1, 5'd20, 1'b1, 2'b10, 2'b10, 4'd8}, // R8 both from one stage
    '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00, 4'd6}, // R6 zero register
    '{5'd0,  5'd8,  5'd0,  1'b1, 5'd8,  1'b1, 2'b00, 2'b01, 4'd6}, // R6 zero at ex stage
    '{5'd11, 5'd11, 5'd11, 1'b0, 5'd11, 1'b1, 2'b01, 2'b01, 4'd7}, // R7 ex stage not writing
    '{5'd4,  5'd4,  5'd4,  1'b0, 5'd4,  1'b0, 2'b00, 2'b00, 4'd7}, // R7 none writing
    '{5'd31, 5'd30, 5'd30, 1'b1, 5'd31, 1'b1, 2'b01, 2'b10, 4'd8}  // R8 top numbers
  };

  logic          clk;
  logic          rst_n;
  logic [RW-1:0] ex_rs, ex_rt, mem_rd, wb_rd;
  logic          mem_wr, wb_wr;
  logic [DW-1:0] ex_a_val, ex_b_val, mem_alu, wb_val;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] op_a, op_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  fwd_unit_top #(.RW(RW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_a_val(ex_a_val), .ex_b_val(ex_b_val),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_alu(mem_alu),
    .wb_rd(wb_rd), .wb_wr(wb_wr), .wb_val(wb_val),
    .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a), .op_b(op_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] idv,
                                         input logic [DW-1:0] exv, input logic [DW-1:0] wbv);
    if (s == 2'b10) return exv;
    if (s == 2'b01) return wbv;
    return idv;
  endfunction

  task automatic apply(input vec_t v, input int k);
    ex_rs = v.rs; ex_rt = v.rt; mem_rd = v.mrd; mem_wr = v.mwr;
    wb_rd = v.wrd; wb_wr = v.wwr;
    ex_a_val = 32'hA000_0000 + k; ex_b_val = 32'hB000_0000 + k;
    mem_alu  = 32'hC000_0000 + k; wb_val   = 32'hD000_0000 + k;
  endtask

  task automatic zero_inputs();
    ex_rs = '0; ex_rt = '0; mem_rd = '0; wb_rd = '0; mem_wr = 1'b0; wb_wr = 1'b0;
    ex_a_val = '0; ex_b_val = '0; mem_alu = '0; wb_val = '0;
  endtask

  initial begin
    zero_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "sel_a in reset", {30'd0, sel_a}, 32'd0);
    check("R1", "sel_b in reset", {30'd0, sel_b}, 32'd0);
    check("R1", "op_a in reset", op_a, 32'd0);
    check("R1", "op_b in reset", op_b, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      apply(VECS[i], i);
      @(negedge clk);
      check(tag, $sformatf("vec %0d sel_a", i), {30'd0, sel_a}, {30'd0, VECS[i].ea});
      check(tag, $sformatf("vec %0d sel_b", i), {30'd0, sel_b}, {30'd0, VECS[i].eb});
      check(tag, $sformatf("vec %0d op_a", i), op_a,
            pick(VECS[i].ea, 32'hA000_0000 + i, 32'hC000_0000 + i, 32'hD000_0000 + i));
      check(tag, $sformatf("vec %0d op_b", i), op_b,
            pick(VECS[i].eb, 32'hB000_0000 + i, 32'hC000_0000 + i, 32'hD000_0000 + i));
    end

    // R9: outputs hold until the next rising edge, then follow.
    apply(VECS[6], 40);
    @(negedge clk);
    apply(VECS[10], 41);
    #1;
    check("R9", "sel_a before edge", {30'd0, sel_a}, 32'd2);
    check("R9", "op_a before edge", op_a, 32'hC000_0000 + 40);
    @(negedge clk);
    check("R9", "sel_b after edge", {30'd0, sel_b}, 32'd1);
    check("R9", "op_b after edge", op_b, 32'hD000_0000 + 41);

    // R1: asynchronous reset clears registered outputs at once.
    apply(VECS[8], 50);
    @(negedge clk);
    zero_inputs();
    rst_n = 1'b0;
    #1;
    check("R1", "sel_a async reset", {30'd0, sel_a}, 32'd0);
    check("R1", "sel_b async reset", {30'd0, sel_b}, 32'd0);
    check("R1", "op_b async reset", op_b, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule